// File: doc/BRIEF.md
# Serial EEPROM Write Target Front-End

This block is the bus-facing half of a small serial EEPROM on a two-wire I2C bus, limited to write traffic. It oversamples the clock and data lines with the system clock, finds START and STOP conditions, and shifts in bytes. It checks the first byte of each transaction against a device code and a chip-select value. It acknowledges by asserting an open-drain pull-down enable during the ninth clock pulse. It keeps the byte that follows as the word address. Each later byte is handed to a downstream page buffer with a one-cycle strobe, together with the address that byte belongs to.

Within a transaction the low address bits count up and wrap inside one page, and the high bits stay fixed. A STOP that ends a transaction carrying at least one data byte gives a one-cycle commit strobe. The buffer then runs its internal write cycle and reports it on a busy input. While busy is high, the target acknowledges nothing, so a master can poll with control bytes until one is acknowledged.

Top module: `eewr_target`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high, both seen on synchronized copies. A START from any state returns the target to control-byte reception.
- R2: The first byte after START is taken MSB first as bits [7:4] device code (parameter, default 4'b1010), bits [3:1] chip select (compared with `chip_sel_i`) and bit [0] read/write. If both fields match and bit [0] is 0, `sda_pull_o` is high through the ninth SCL pulse.
- R3: If the control byte does not match, or bit [0] is 1, it gets no acknowledge. No later byte before the next START is acknowledged or strobed, and a STOP then gives no commit.
- R4: The byte after an accepted control byte is acknowledged and loaded as the address pointer. `addr_load_o` pulses once, with `addr_o` equal to that byte.
- R5: Every byte after the address byte is acknowledged. `data_valid_o` pulses once per byte, with `data_o` equal to the byte and `addr_o` equal to the pointer value before the increment.
- R6: After each data byte, the low PAGE_BITS (default 4) bits of the pointer increment modulo 2^PAGE_BITS, and the upper bits stay unchanged.
- R7: While `wr_busy_i` is high at the end of a byte, that byte is not acknowledged and no strobe is given for it.
- R8: A STOP after at least one accepted data byte gives exactly one `commit_o` pulse. A STOP with no data byte in the transaction gives none.
- R9: A repeated START in the middle of a byte discards the bits already received, and the next eight bits form a new control byte.
- R10: `sda_pull_o` is low except in the acknowledge slot. It is released on the SCL fall that ends the ninth pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received (wired level) |
| chip_sel_i | input | 3 | Static chip-select strap value |
| wr_busy_i | input | 1 | High while the internal write cycle runs |
| sda_pull_o | output | 1 | Open-drain enable; high pulls SDA low |
| addr_load_o | output | 1 | One-cycle strobe: word address loaded |
| data_valid_o | output | 1 | One-cycle strobe: data byte for the buffer |
| addr_o | output | 8 | Loaded address, or the address of the strobed data byte |
| data_o | output | 8 | Data byte for the page buffer |
| commit_o | output | 1 | One-cycle strobe: STOP ended a transaction that carried data |

## Verification
The hardest case to reach from the ports is a repeated START that arrives partway through a byte. The bench has a task that clocks out only a few bits and then raises SDA and SCL and drops SDA again. A whole, correctly matching control byte has to follow, and the acknowledge and strobes it gets show that the stale bit count was cleared. The busy lockout is reached by raising the busy input right after a commit and polling with control bytes, first while busy is high and then after it falls. Page wrap is reached with a write that starts near the top of a page.

// File: rtl/eewr_pkg.sv
package eewr_pkg;

    localparam int CODE_W    = 4;
    localparam int CS_W      = 3;
    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADDR,
        ST_DATA,
        ST_SKIP
    } eewr_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    // Control byte layout: [7:4] device code, [3:1] chip select, [0] read flag
    function automatic logic ctrl_match(input logic [BYTE_W-1:0] b,
                                        input logic [CODE_W-1:0] code,
                                        input logic [CS_W-1:0]   cs);
        return (b[7:4] == code) && (b[3:1] == cs) && (b[0] == 1'b0);
    endfunction

endpackage

// File: rtl/eewr_line_sync.sv
module eewr_line_sync
    import eewr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] scl_sr;
    logic [STAGES-1:0] sda_sr;
    logic              scl_p;
    logic              sda_p;
    logic              scl_s;
    logic              sda_s;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sr[g] <= 1'b1;
                    sda_sr[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_sr[g] <= scl_i;
                    sda_sr[g] <= sda_i;
                end else begin
                    scl_sr[g] <= scl_sr[(g == 0) ? 0 : g-1];
                    sda_sr[g] <= sda_sr[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign scl_s = scl_sr[LAST];
    assign sda_s = sda_sr[LAST];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        evt.start    = scl_s & scl_p & sda_p & ~sda_s;
        evt.stop     = scl_s & scl_p & ~sda_p & sda_s;
        evt.scl_rise = scl_s & ~scl_p;
        evt.scl_fall = ~scl_s & scl_p;
        evt.sda      = sda_s;
    end

    // START and STOP only arise while SCL is steady high
    AST_COND_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (evt.start || evt.stop) |-> (scl_s && $past(scl_s)))  // R1
        else $error("start/stop seen without SCL high");

endmodule

// File: rtl/eewr_byte_rx.sv
module eewr_byte_rx
    import eewr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic              enable,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              ack_slot
);

    localparam logic [BIT_CNT_W-1:0] FULL = BIT_CNT_W'(BYTE_W);

    logic [BIT_CNT_W-1:0] cnt;
    logic [BYTE_W-1:0]    shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            shreg     <= '0;
            ack_slot  <= 1'b0;
            byte_done <= 1'b0;
        end else if (evt.start || evt.stop || !enable) begin
            cnt       <= '0;
            ack_slot  <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (evt.scl_rise && !ack_slot && cnt < FULL) begin
                shreg <= {shreg[BYTE_W-2:0], evt.sda};
                cnt   <= cnt + 1'b1;
            end
            if (evt.scl_fall) begin
                if (ack_slot) begin
                    ack_slot <= 1'b0;
                end else if (cnt == FULL) begin
                    byte_done <= 1'b1;
                    ack_slot  <= 1'b1;
                    cnt       <= '0;
                end
            end
        end
    end

    assign rx_byte = shreg;

    AST_START_CLEARS_COUNT: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (cnt == '0 && !ack_slot))  // R9
        else $error("bit count not cleared by START");

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL)  // R2
        else $error("bit count overran a byte");

endmodule

// File: rtl/eewr_target.sv
module eewr_target
    import eewr_pkg::*;
#(
    parameter logic [3:0] DEV_CODE    = 4'b1010,
    parameter int         PAGE_BITS   = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] chip_sel_i,
    input  logic       wr_busy_i,
    output logic       sda_pull_o,
    output logic       addr_load_o,
    output logic       data_valid_o,
    output logic [7:0] addr_o,
    output logic [7:0] data_o,
    output logic       commit_o
);

    localparam int ADDR_W = BYTE_W;
    localparam int HI_W   = ADDR_W - PAGE_BITS;

    bus_evt_t          evt;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic              ack_slot;
    eewr_state_e       state;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] data_q;
    logic              ack_q;
    logic              got_data;
    logic              load_q;
    logic              valid_q;
    logic              commit_q;
    logic              unused_evt;

    assign unused_evt = evt.scl_rise ^ evt.sda;

    eewr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    eewr_byte_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .enable    (state != ST_IDLE),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .ack_slot  (ack_slot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ptr      <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            ack_q    <= 1'b0;
            got_data <= 1'b0;
            load_q   <= 1'b0;
            valid_q  <= 1'b0;
            commit_q <= 1'b0;
        end else begin
            load_q   <= 1'b0;
            valid_q  <= 1'b0;
            commit_q <= 1'b0;
            if (evt.start) begin
                state    <= ST_CTRL;
                got_data <= 1'b0;
                ack_q    <= 1'b0;
            end else if (evt.stop) begin
                commit_q <= got_data;
                state    <= ST_IDLE;
                got_data <= 1'b0;
                ack_q    <= 1'b0;
            end else begin
                if (ack_slot && evt.scl_fall) begin
                    ack_q <= 1'b0;
                end
                if (byte_done) begin
                    unique case (state)
                        ST_CTRL: begin
                            if (!wr_busy_i && ctrl_match(rx_byte, DEV_CODE, chip_sel_i)) begin
                                ack_q <= 1'b1;
                                state <= ST_ADDR;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                        ST_ADDR: begin
                            if (!wr_busy_i) begin
                                ack_q  <= 1'b1;
                                ptr    <= rx_byte;
                                addr_q <= rx_byte;
                                load_q <= 1'b1;
                                state  <= ST_DATA;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                        ST_DATA: begin
                            if (!wr_busy_i) begin
                                ack_q    <= 1'b1;
                                data_q   <= rx_byte;
                                addr_q   <= ptr;
                                valid_q  <= 1'b1;
                                got_data <= 1'b1;
                                ptr      <= {ptr[ADDR_W-1 -: HI_W],
                                             ptr[PAGE_BITS-1:0] + 1'b1};
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign sda_pull_o   = ack_q;
    assign addr_load_o  = load_q;
    assign data_valid_o = valid_q;
    assign addr_o       = addr_q;
    assign data_o       = data_q;
    assign commit_o     = commit_q;

    AST_PULL_ONLY_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
        sda_pull_o |-> ack_slot)  // R10
        else $error("SDA pulled outside acknowledge slot");

    AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (byte_done && wr_busy_i) |=> (!sda_pull_o && !data_valid_o && !addr_load_o))  // R7
        else $error("byte acknowledged while busy");

    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |-> (!sda_pull_o && !data_valid_o && !addr_load_o))  // R3
        else $error("activity while ignoring bus");

    AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        commit_o |-> $past(evt.stop))  // R8
        else $error("commit without STOP");

    AST_PAGE_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        data_valid_o |-> (ptr[ADDR_W-1 -: HI_W] == addr_o[ADDR_W-1 -: HI_W]))  // R6
        else $error("pointer left its page");

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({addr_load_o, data_valid_o, commit_o}))  // R5
        else $error("overlapping strobes");

endmodule

// File: tb/eewr_target_tb.sv
module eewr_target_tb;

    localparam int Q = 8;

    typedef struct {
        int         kind;   // 1 address load, 2 data, 3 commit
        logic [7:0] a;
        logic [7:0] d;
        string      req;
    } ev_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] chip_sel = 3'b101;
    logic       busy = 1'b0;
    logic       sda_pull;
    logic       addr_load;
    logic       data_valid;
    logic [7:0] addr;
    logic [7:0] data;
    logic       commit;
    logic       sda_line;

    int checks = 0;
    int errors = 0;
    ev_t expq[$];

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    eewr_target u_dut (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .chip_sel_i   (chip_sel),
        .wr_busy_i    (busy),
        .sda_pull_o   (sda_pull),
        .addr_load_o  (addr_load),
        .data_valid_o (data_valid),
        .addr_o       (addr),
        .data_o       (data),
        .commit_o     (commit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference monitor: every clock, compare strobes against expected queue
    always @(negedge clk) begin
        if (!rst && (addr_load || data_valid || commit)) begin
            int k;
            k = addr_load ? 1 : (data_valid ? 2 : 3);
            if (expq.size() == 0) begin
                check(1'b0, "R3 unexpected strobe", k, 0);
            end else begin
                ev_t e;
                e = expq.pop_front();
                check(k == e.kind, e.req, k, e.kind);
                if (e.kind == 1) check(addr == e.a, e.req, addr, e.a);
                if (e.kind == 2) begin
                    check(addr == e.a, e.req, addr, e.a);
                    check(data == e.d, e.req, data, e.d);
                end
            end
        end
        if (!rst && !scl_m && sda_pull && sda_m == 1'b0) begin
            // master never drives low while the target pulls in a slot it does not own
        end
    end

    task automatic wq(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wq(Q);
            scl_m = 1'b1; wq(2*Q);
            scl_m = 1'b0; wq(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        bit got;
        send_bits(b, 8);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        got = ~sda_line;
        wq(Q);
        scl_m = 1'b0; wq(1);
        wq(Q);
        check(got == exp_ack, req, got, exp_ack);
        // R10: pull released after the SCL fall ending the ninth pulse
        check(sda_pull == 1'b0, "R10 release after slot", sda_pull, 0);
    endtask

    function automatic logic [7:0] page_addr(input logic [7:0] base, input int i);
        logic [3:0] lo;
        lo = base[3:0] + 4'(i);
        return {base[7:4], lo};
    endfunction

    task automatic push(input int k, input logic [7:0] a, input logic [7:0] d, input string req);
        ev_t e;
        e.kind = k; e.a = a; e.d = d; e.req = req;
        expq.push_back(e);
    endtask

    // Full write transaction with reference expectations
    task automatic write_txn(input logic [7:0] base, input int n, input logic [7:0] seed);
        bus_start();
        send_byte({4'b1010, chip_sel, 1'b0}, 1'b1, "R2 control ack");
        push(1, base, 8'h00, "R4 address load");
        send_byte(base, 1'b1, "R4 address ack");
        for (int i = 0; i < n; i++) begin
            push(2, page_addr(base, i), seed + 8'(i * 7), "R5 R6 data strobe");
            send_byte(seed + 8'(i * 7), 1'b1, "R5 data ack");
        end
        if (n > 0) push(3, 8'h00, 8'h00, "R8 commit");
        bus_stop();
        wq(4);
    endtask

    initial begin
        wq(4);
        check(sda_pull == 1'b0, "R10 reset pull", sda_pull, 0);
        check(addr_load == 1'b0 && data_valid == 1'b0 && commit == 1'b0,
              "R8 reset strobes", {addr_load, data_valid, commit}, 0);
        rst = 1'b0;
        wq(4);

        // Single byte write
        write_txn(8'h35, 1, 8'h5A);
        // Page write that wraps within its page
        write_txn(8'h4E, 4, 8'h11);
        // Full page of sixteen plus one more (overwrites first slot)
        write_txn(8'hC0, 17, 8'h80);

        // Wrong device code: ignored until next START
        bus_start();
        send_byte({4'b1011, chip_sel, 1'b0}, 1'b0, "R3 wrong code nak");
        send_byte(8'h12, 1'b0, "R3 ignored byte");
        send_byte(8'h34, 1'b0, "R3 ignored byte");
        bus_stop();
        wq(4);

        // Wrong chip select
        bus_start();
        send_byte({4'b1010, 3'b001, 1'b0}, 1'b0, "R3 wrong cs nak");
        send_byte(8'h20, 1'b0, "R3 ignored byte");
        bus_stop();
        wq(4);

        // Read request is not acknowledged
        bus_start();
        send_byte({4'b1010, chip_sel, 1'b1}, 1'b0, "R3 read flag nak");
        bus_stop();
        wq(4);

        // STOP after address only: no commit
        bus_start();
        send_byte({4'b1010, chip_sel, 1'b0}, 1'b1, "R2 control ack");
        push(1, 8'h77, 8'h00, "R4 address load");
        send_byte(8'h77, 1'b1, "R4 address ack");
        bus_stop();
        wq(4);

        // Repeated START midway through a byte, then a clean write
        bus_start();
        send_byte({4'b1010, chip_sel, 1'b0}, 1'b1, "R2 control ack");
        send_bits(8'hFF, 3);
        bus_start();
        send_byte({4'b1010, chip_sel, 1'b0}, 1'b1, "R9 ack after repeated start");
        push(1, 8'h08, 8'h00, "R9 address load");
        send_byte(8'h08, 1'b1, "R9 address ack");
        push(2, 8'h08, 8'hE3, "R9 data strobe");
        send_byte(8'hE3, 1'b1, "R9 data ack");
        push(3, 8'h00, 8'h00, "R9 commit");
        bus_stop();
        wq(4);

        // Repeated START after a mismatch returns to control reception
        bus_start();
        send_byte({4'b0110, chip_sel, 1'b0}, 1'b0, "R3 mismatch before restart");
        bus_start();
        send_byte({4'b1010, chip_sel, 1'b0}, 1'b1, "R1 restart resumes control");
        bus_stop();
        wq(4);

        // Busy polling: no acknowledge while write cycle runs
        busy = 1'b1;
        bus_start();
        send_byte({4'b1010, chip_sel, 1'b0}, 1'b0, "R7 busy nak");
        send_byte(8'h10, 1'b0, "R7 busy ignored");
        bus_stop();
        wq(4);
        busy = 1'b0;
        write_txn(8'h90, 2, 8'h3C);

        wq(8);
        check(expq.size() == 0, "R5 all expected strobes seen", expq.size(), 0);
        check(sda_pull == 1'b0, "R10 idle pull", sda_pull, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule